// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static RAM whose data bus never needs an idle cycle when traffic switches between reading and writing. Every input is captured on the rising clock edge. An access travels through two registered stages. A read returns its word from an output register. A write takes its data two enabled cycles after its address, so a read and a write can be issued on consecutive cycles in any mix.

Two inputs control each cycle. The first is an active-low clock enable that freezes the whole pipeline. The second is an access control that either starts a new access from the address bus or advances a four-beat burst. The burst runs in linear or interleaved order. Each 9-bit byte lane has its own active-low write enable.

The shared data bus is modelled as separate write-data and read-data ports plus a drive-enable flag. Depth and lane count are parameters. The default depth is 1K words so that the default build stays small. With 17 address bits and two lanes the model gives 128K x 18. With 16 bits and four lanes it gives 64K x 36.

Top module: `zbt_sram`

## Requirements
- R1: After a cycle with `rst_n` low at the clock edge, `rdata_oe` is 0 and `rdata` is 0 until a read reaches the output.
- R2: A selected read whose address is captured at enabled edge k gives `rdata` equal to the stored word and `rdata_oe` high from enabled edge k+2 on.
- R3: For a selected write whose address is captured at enabled edge k, the word on `wdata` at enabled edge k+2 is stored at that address.
- R4: Reads and writes may be issued on every consecutive enabled cycle in any mix. A read issued one cycle after a write to the same address returns the newly written data.
- R5: Byte lane i is bits [9i+8:9i]. During a write, a lane whose `wlane_n[i]` is 1 keeps its stored contents, and a lane whose bit is 0 takes the new data.
- R6: A cycle that starts an access (`burst_adv`=0) is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other combination is a deselect, which writes nothing and produces no output.
- R7: While `en_n` is 1 at a clock edge, no state changes. `rdata` and `rdata_oe` hold their values, and that cycle's other inputs are ignored.
- R8: With `order_xor`=0, advance cycles after a start at address A use the low two bits (A+n) mod 4 for beat n. The upper bits stay those of A, and the sequence wraps after four beats.
- R9: With `order_xor`=1, beat n of a burst uses the low two bits A[1:0] XOR n.
- R10: An advance cycle keeps the read/write direction of the access that started the burst. `is_read` is ignored on advance cycles.
- R11: `rdata_oe` is 0 in the output slot of a write or a deselect cycle.
- R12: An advance cycle that follows a deselect is itself a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the control pipeline |
| en_n | input | 1 | Active-low clock enable; 1 freezes the block |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| is_read | input | 1 | 1 = read, 0 = write (start cycles only) |
| burst_adv | input | 1 | 0 = start access from `addr`, 1 = advance burst |
| order_xor | input | 1 | Burst order: 0 linear, 1 interleaved |
| wlane_n | input | LANES | Per-lane write enable, active low |
| addr | input | AW | Word address |
| wdata | input | LANES*9 | Write data, two enabled cycles behind its address |
| rdata | output | LANES*9 | Registered read data |
| rdata_oe | output | 1 | High while `rdata` carries a valid read word |

## Verification
A corrupted stage valid or direction bit shows at the ports two enabled cycles later. `rdata_oe` then rises in the slot of a write, or stays low in the slot of a read. A wrong burst counter or base register shows in the second beat of a burst, as a word read from the wrong address. A write committed with the wrong data or lane mask stays hidden until that address is read back, so every write in the bench is followed by a read of the same address. A frozen cycle that leaks through shows at once as a change on `rdata` or `rdata_oe` while `en_n` is high.

// File: rtl/zbt_pkg.sv
// Package: shared constants and burst ordering helper for the zero-turnaround SRAM.
// Assumes bursts are exactly four beats, addressed by the two low address bits.
package zbt_pkg;

    localparam int LANE_W = 9;

    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } dir_e;

    // Low-bit offset of burst beat `count` from start bits `start`.
    function automatic logic [1:0] beat_offset(
        input logic [1:0] start,
        input logic [1:0] count,
        input logic       interleave
    );
        logic [1:0] r;
        if (interleave) r = start ^ count;
        else            r = start + count;
        return r;
    endfunction

endpackage

// File: rtl/zbt_burst.sv
// Burst address generator. On a start cycle it passes the external address and
// selection through and remembers them. On an advance cycle it produces the
// next beat address with the stored direction. Assumes AW >= 3.
module zbt_burst #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_n,
    input  logic          sel_ok,
    input  logic          burst_adv,
    input  logic          is_read,
    input  logic          order_xor,
    input  logic [AW-1:0] addr,
    output logic          acc_valid,
    output logic          acc_rd,
    output logic [AW-1:0] acc_addr
);
    import zbt_pkg::*;

    logic [AW-1:0] base_q;
    logic [1:0]    cnt_q;
    logic          act_q;
    dir_e          dir_q;

    // Resolve this cycle's access from either the bus or the burst state.
    always_comb begin
        if (!burst_adv) begin
            acc_valid = sel_ok;
            acc_rd    = is_read;
            acc_addr  = addr;
        end else begin
            acc_valid = act_q;
            acc_rd    = (dir_q == DIR_READ);
            acc_addr  = {base_q[AW-1:2], beat_offset(base_q[1:0], cnt_q, order_xor)};
        end
    end

    // Keep burst base, beat count, direction and activity across enabled cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            cnt_q  <= 2'd0;
            base_q <= '0;
            dir_q  <= DIR_READ;
        end else if (!en_n) begin
            if (!burst_adv) begin
                act_q  <= sel_ok;
                base_q <= addr;
                cnt_q  <= 2'd1;
                dir_q  <= is_read ? DIR_READ : DIR_WRITE;
            end else if (act_q) begin
                cnt_q  <= cnt_q + 2'd1;
            end
        end
    end

endmodule

// File: rtl/zbt_pipe.sv
// Two-stage access pipeline carrying valid, direction, address and lane mask.
// The head stage holds the most recent captured access; the tail stage feeds the
// array. Assumes STAGES >= 2; every stage holds while the clock enable is off.
module zbt_pipe #(
    parameter int AW     = 10,
    parameter int LANES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_n,
    input  logic             in_valid,
    input  logic             in_rd,
    input  logic [AW-1:0]    in_addr,
    input  logic [LANES-1:0] in_mask_n,
    output logic             head_valid,
    output logic             head_rd,
    output logic [AW-1:0]    head_addr,
    output logic             op_valid,
    output logic             op_rd,
    output logic [AW-1:0]    op_addr,
    output logic [LANES-1:0] op_mask_n
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] v_q;
    logic [STAGES-1:0] rd_q;
    logic [AW-1:0]     a_q [STAGES];
    logic [LANES-1:0]  m_q [STAGES];

    // Shift every stage forward by one on each enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
        end else if (!en_n) begin
            v_q[0] <= in_valid;
            for (int s = 1; s < STAGES; s++) v_q[s] <= v_q[s-1];
        end
    end

    // Move the payload of each stage; payload needs no reset.
    always_ff @(posedge clk) begin
        if (!en_n) begin
            rd_q[0] <= in_rd;
            a_q[0]  <= in_addr;
            m_q[0]  <= in_mask_n;
            for (int s = 1; s < STAGES; s++) begin
                rd_q[s] <= rd_q[s-1];
                a_q[s]  <= a_q[s-1];
                m_q[s]  <= m_q[s-1];
            end
        end
    end

    assign head_valid = v_q[0];
    assign head_rd    = rd_q[0];
    assign head_addr  = a_q[0];
    assign op_valid   = v_q[LAST];
    assign op_rd      = rd_q[LAST];
    assign op_addr    = a_q[LAST];
    assign op_mask_n  = m_q[LAST];

endmodule

// File: rtl/zbt_array.sv
// Byte-maskable storage with a registered read port. A write commits as its access
// leaves the pipeline, using wdata from that same edge; a read samples the array at
// the same point, so earlier writes are always visible. Memory is not reset.
module zbt_array #(
    parameter int AW    = 10,
    parameter int LANES = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           en_n,
    input  logic                           op_valid,
    input  logic                           op_rd,
    input  logic [AW-1:0]                  op_addr,
    input  logic [LANES-1:0]               op_mask_n,
    input  logic [LANES*zbt_pkg::LANE_W-1:0] wdata,
    output logic [LANES*zbt_pkg::LANE_W-1:0] rdata,
    output logic                           rdata_oe
);
    import zbt_pkg::*;

    localparam int DEPTH = 1 << AW;

    logic do_rd;
    logic do_wr;

    assign do_rd = !en_n && op_valid && op_rd;
    assign do_wr = !en_n && op_valid && !op_rd;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] out_q;

        // Store this lane when the write reaches the array and its enable is low.
        always_ff @(posedge clk) begin
            if (do_wr && !op_mask_n[g]) mem[op_addr] <= wdata[g*LANE_W +: LANE_W];
        end

        // Register this lane's read word; hold it otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n)     out_q <= '0;
            else if (do_rd) out_q <= mem[op_addr];
        end

        assign rdata[g*LANE_W +: LANE_W] = out_q;
    end

    // Flag valid read data for exactly the enabled cycle after a read leaves.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_oe <= 1'b0;
        else if (!en_n) rdata_oe <= op_valid && op_rd;
    end

    AST_OE_ON_READ:   assert property (@(posedge clk) disable iff (!rst_n) do_rd |=> rdata_oe); // R2
    AST_OE_OFF_OTHER: assert property (@(posedge clk) disable iff (!rst_n) (!en_n && !(op_valid && op_rd)) |=> !rdata_oe); // R11
    AST_FREEZE_OUT:   assert property (@(posedge clk) disable iff (!rst_n) en_n |=> ($stable(rdata) && $stable(rdata_oe))); // R7

endmodule

// File: rtl/zbt_sram.sv
// Top of the zero-turnaround pipelined SRAM. Decodes the three chip selects,
// forms the access through the burst generator, carries it through the two-stage
// pipeline and applies it to the byte-lane array. Assumes AW >= 3.
module zbt_sram #(
    parameter int AW    = 10,
    parameter int LANES = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           en_n,
    input  logic                           sel_a_n,
    input  logic                           sel_b,
    input  logic                           sel_c_n,
    input  logic                           is_read,
    input  logic                           burst_adv,
    input  logic                           order_xor,
    input  logic [LANES-1:0]               wlane_n,
    input  logic [AW-1:0]                  addr,
    input  logic [LANES*zbt_pkg::LANE_W-1:0] wdata,
    output logic [LANES*zbt_pkg::LANE_W-1:0] rdata,
    output logic                           rdata_oe
);
    localparam int STAGES = 2;

    logic             sel_ok;
    logic             acc_valid;
    logic             acc_rd;
    logic [AW-1:0]    acc_addr;
    logic             head_valid;
    logic             head_rd;
    logic [AW-1:0]    head_addr;
    logic             op_valid;
    logic             op_rd;
    logic [AW-1:0]    op_addr;
    logic [LANES-1:0] op_mask_n;

    // Device is selected only with all three chip selects active.
    assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

    zbt_burst #(.AW(AW)) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_n      (en_n),
        .sel_ok    (sel_ok),
        .burst_adv (burst_adv),
        .is_read   (is_read),
        .order_xor (order_xor),
        .addr      (addr),
        .acc_valid (acc_valid),
        .acc_rd    (acc_rd),
        .acc_addr  (acc_addr)
    );

    zbt_pipe #(.AW(AW), .LANES(LANES), .STAGES(STAGES)) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_n       (en_n),
        .in_valid   (acc_valid),
        .in_rd      (acc_rd),
        .in_addr    (acc_addr),
        .in_mask_n  (wlane_n),
        .head_valid (head_valid),
        .head_rd    (head_rd),
        .head_addr  (head_addr),
        .op_valid   (op_valid),
        .op_rd      (op_rd),
        .op_addr    (op_addr),
        .op_mask_n  (op_mask_n)
    );

    zbt_array #(.AW(AW), .LANES(LANES)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_n      (en_n),
        .op_valid  (op_valid),
        .op_rd     (op_rd),
        .op_addr   (op_addr),
        .op_mask_n (op_mask_n),
        .wdata     (wdata),
        .rdata     (rdata),
        .rdata_oe  (rdata_oe)
    );

    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!en_n && !burst_adv && !sel_ok) |=> !head_valid); // R6
    AST_BURST_UPPER:   assert property (@(posedge clk) disable iff (!rst_n) (!en_n && burst_adv && acc_valid) |-> (acc_addr[AW-1:2] == head_addr[AW-1:2])); // R8
    AST_BURST_DIR:     assert property (@(posedge clk) disable iff (!rst_n) (!en_n && burst_adv && acc_valid) |-> (acc_rd == head_rd)); // R10
    AST_ADV_AFTER_DES: assert property (@(posedge clk) disable iff (!rst_n) (!en_n && burst_adv && !head_valid) |-> !acc_valid); // R12

endmodule

// File: tb/zbt_sram_test.sv
// Scoreboard bench: the driver task resolves each access with an independent model,
// pushes the expected output slot into a queue, and the monitor pops and compares.
module zbt_sram_test;
    localparam int CLK_P = 10;
    localparam int AW    = 10;
    localparam int LANES = 2;
    localparam int LW    = 9;
    localparam int DW    = LANES * LW;
    localparam logic [2:0] SEL = 3'b010;   // {sel_a_n, sel_b, sel_c_n}

    logic clk = 1'b0;
    logic rst_n, en_n, sel_a_n, sel_b, sel_c_n, is_read, burst_adv, order_xor;
    logic [LANES-1:0] wlane_n;
    logic [AW-1:0]    addr;
    logic [DW-1:0]    wdata, rdata;
    logic             rdata_oe;

    zbt_sram #(.AW(AW), .LANES(LANES)) uut (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .sel_c_n(sel_c_n), .is_read(is_read), .burst_adv(burst_adv),
        .order_xor(order_xor), .wlane_n(wlane_n), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rdata_oe(rdata_oe)
    );

    always #(CLK_P/2) clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit started = 0;

    bit            q_en [$];
    logic [DW-1:0] q_dat [$];
    string         q_req [$];

    logic [DW-1:0]    refm [int];
    bit               p_v [2];
    bit               p_rd [2];
    logic [AW-1:0]    p_a [2];
    logic [LANES-1:0] p_m [2];
    logic [DW-1:0]    p_wd [2];
    string            p_req [2];

    bit            b_act = 0;
    bit            b_rd = 0;
    logic [AW-1:0] b_base = '0;
    logic [1:0]    b_cnt = '0;

    task automatic chk(input string req, input bit ok, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one enabled cycle and push the expected result of the access leaving stage two.
    task automatic op(input logic [2:0] ces, input bit rw, input bit adv, input bit ilv,
                      input logic [LANES-1:0] msk, input logic [AW-1:0] a,
                      input logic [DW-1:0] wd, input string req);
        bit nv, nrd;
        logic [AW-1:0] na;
        logic [DW-1:0] dr, old;
        @(negedge clk);
        if (!adv) begin
            nv = (ces == SEL); nrd = rw; na = a;
            b_act = nv; b_base = a; b_cnt = 2'd1; b_rd = rw;
        end else begin
            nv = b_act; nrd = b_rd;
            na = {b_base[AW-1:2], ilv ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt)};
            if (b_act) b_cnt = b_cnt + 2'd1;
        end
        dr = '0;
        if (p_v[1] && !p_rd[1]) begin
            dr  = p_wd[1];
            old = refm.exists(int'(p_a[1])) ? refm[int'(p_a[1])] : '0;
            for (int l = 0; l < LANES; l++)
                if (!p_m[1][l]) old[l*LW +: LW] = dr[l*LW +: LW];
            refm[int'(p_a[1])] = old;
            q_en.push_back(1'b0); q_dat.push_back('0);
        end else if (p_v[1]) begin
            q_en.push_back(1'b1); q_dat.push_back(refm[int'(p_a[1])]);
        end else begin
            q_en.push_back(1'b0); q_dat.push_back('0);
        end
        q_req.push_back(p_req[1]);
        p_v[1] = p_v[0]; p_rd[1] = p_rd[0]; p_a[1] = p_a[0]; p_m[1] = p_m[0];
        p_wd[1] = p_wd[0]; p_req[1] = p_req[0];
        p_v[0] = nv; p_rd[0] = nrd; p_a[0] = na; p_m[0] = msk; p_wd[0] = wd; p_req[0] = req;
        en_n = 1'b0; {sel_a_n, sel_b, sel_c_n} = ces; is_read = rw; burst_adv = adv;
        order_xor = ilv; wlane_n = msk; addr = a; wdata = dr;
    endtask

    // Hold the clock enable off for n cycles while presenting a junk write.
    task automatic freeze(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            en_n = 1'b1; {sel_a_n, sel_b, sel_c_n} = SEL; is_read = 1'b0; burst_adv = 1'b0;
            wlane_n = '0; addr = AW'(6); wdata = 18'h2BEEF ^ DW'(i);
        end
    endtask

    // Monitor: pop one expected slot per enabled edge; check hold on frozen edges (R7).
    initial begin
        bit en, fr, e;
        logic [DW-1:0] d, prev_d;
        logic prev_e;
        string r;
        prev_d = '0; prev_e = 1'b0;
        forever begin
            @(posedge clk);
            en = rst_n && !en_n && started;
            fr = rst_n && en_n && started;
            #(CLK_P/4);
            if (en && q_en.size() > 0) begin
                e = q_en.pop_front(); d = q_dat.pop_front(); r = q_req.pop_front();
                chk(r, rdata_oe === e, DW'(rdata_oe), DW'(e));
                if (e) chk(r, rdata === d, rdata, d);
            end
            if (fr) chk("R7", (rdata === prev_d) && (rdata_oe === prev_e), rdata, prev_d);
            prev_d = rdata; prev_e = rdata_oe;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        p_v[0] = 0; p_v[1] = 0; p_req[0] = "R11"; p_req[1] = "R11";
        rst_n = 0; en_n = 0; {sel_a_n, sel_b, sel_c_n} = 3'b101; is_read = 1; burst_adv = 0;
        order_xor = 0; wlane_n = '1; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        chk("R1", rdata_oe === 1'b0, DW'(rdata_oe), '0);
        chk("R1", rdata === '0, rdata, '0);
        rst_n = 1; started = 1;
        // R3 writes then R2 reads
        for (int i = 0; i < 8; i++) op(SEL, 0, 0, 0, '0, AW'(i), DW'(i * 18'h1111 + 5), "R3");
        for (int i = 0; i < 8; i++) op(SEL, 1, 0, 0, '0, AW'(i), '0, "R2");
        // R4 back-to-back mix with same-address turnaround; R11 on write slots
        op(SEL, 0, 0, 0, '0, AW'(30), 18'h3A5A5, "R11");
        op(SEL, 1, 0, 0, '0, AW'(30), '0, "R4");
        op(SEL, 0, 0, 0, '0, AW'(31), 18'h0F0F0, "R11");
        op(SEL, 1, 0, 0, '0, AW'(30), '0, "R4");
        op(SEL, 1, 0, 0, '0, AW'(31), '0, "R4");
        op(SEL, 0, 0, 0, '0, AW'(30), 18'h12345, "R4");
        op(SEL, 1, 0, 0, '0, AW'(30), '0, "R4");
        // R5 lane masks
        op(SEL, 0, 0, 0, 2'b01, AW'(2), 18'h3FFFF, "R5");
        op(SEL, 0, 0, 0, 2'b10, AW'(3), 18'h3FFFF, "R5");
        op(SEL, 0, 0, 0, 2'b11, AW'(4), 18'h3FFFF, "R5");
        op(SEL, 1, 0, 0, '0, AW'(2), '0, "R5");
        op(SEL, 1, 0, 0, '0, AW'(3), '0, "R5");
        op(SEL, 1, 0, 0, '0, AW'(4), '0, "R5");
        // R6 every partial selection is a deselect
        op(3'b110, 0, 0, 0, '0, AW'(5), 18'h00BAD, "R6");
        op(3'b000, 0, 0, 0, '0, AW'(5), 18'h00BAD, "R6");
        op(3'b011, 0, 0, 0, '0, AW'(5), 18'h00BAD, "R6");
        op(3'b010, 1, 0, 0, '0, AW'(5), '0, "R6");
        // R7 freeze with pending accesses and junk inputs
        op(SEL, 1, 0, 0, '0, AW'(6), '0, "R7");
        op(SEL, 1, 0, 0, '0, AW'(7), '0, "R7");
        freeze(3);
        op(SEL, 1, 0, 0, '0, AW'(6), '0, "R7");
        // R8 linear write burst from 0x41, linear read burst from 0x42 with wrap
        op(SEL, 0, 0, 0, '0, AW'('h41), 18'h11111, "R8");
        op(SEL, 1, 1, 0, '0, AW'(0), 18'h22222, "R8");
        op(SEL, 1, 1, 0, '0, AW'(0), 18'h33333, "R8");
        op(SEL, 1, 1, 0, '0, AW'(0), 18'h04444, "R8");
        op(SEL, 1, 0, 0, '0, AW'('h42), '0, "R8");
        for (int i = 0; i < 4; i++) op(SEL, 1, 1, 0, '0, AW'(0), '0, "R8");
        // R9 interleaved read burst from 0x43
        op(SEL, 1, 0, 1, '0, AW'('h43), '0, "R9");
        for (int i = 0; i < 3; i++) op(SEL, 1, 1, 1, '0, AW'(0), '0, "R9");
        // R10 direction kept while is_read toggles
        op(SEL, 1, 0, 0, '0, AW'('h41), '0, "R10");
        op(SEL, 0, 1, 0, '0, AW'(0), 18'h00BAD, "R10");
        op(SEL, 0, 1, 0, '0, AW'(0), 18'h00BAD, "R10");
        // R12 advance after deselect does nothing
        op(3'b000, 0, 0, 0, '0, AW'('h40), '0, "R12");
        op(SEL, 0, 1, 0, '0, AW'(0), 18'h00BAD, "R12");
        op(SEL, 0, 1, 0, '0, AW'(0), 18'h00BAD, "R12");
        op(SEL, 1, 0, 0, '0, AW'('h40), '0, "R12");
        op(SEL, 1, 0, 0, '0, AW'('h41), '0, "R12");
        for (int i = 0; i < 3; i++) op(3'b000, 1, 0, 0, '1, '0, '0, "R11");
        @(negedge clk);
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule